// File: doc/BRIEF.md
# HDLC Receive Queue with Sticky Event Status

This block sits behind a serial-link deframer that has already removed bit stuffing, found the flags and checked the CRC. Received bytes arrive on a write port, each tagged as the first or last byte of a message, and are held in a 64-entry queue. A downstream reader pulls them out in order, together with first-byte and last-byte flags. The deframer also pulses one strobe each for a good message end, a CRC failure and an abort.

Six sticky event bits collect what has happened: the queue went non-empty, the queue rose above a programmable high-water level, an opening byte arrived, a message ended (well or badly), an opening byte reached the read head, and a packet was cut short because the queue was full. The host reads the bits through a read strobe. That read returns them and clears them, unless the same event fires again in that cycle. A per-bit enable mask gates the bits onto a single interrupt line. When a write finds the queue full, the packet is terminated. Its remaining bytes are dropped until the next opening byte, and the bytes already queued stay readable.

Top module: `hdlc_rxq_status`

## Requirements
- R1: After reset the queue is empty (`rd_valid` = 0), every status bit reads 0 and `irq` is 0.
- R2: Bytes leave in write order, each with the first and last flags it was written with. The queue accepts 64 bytes before it is full.
- R3: Status bit 0 (value 0x01) sets when the queue goes from empty to non-empty. It does not set again while the queue stays non-empty.
- R4: Status bit 1 (value 0x02) sets when the byte count rises from not above `hwm_level` to above it.
- R5: Status bit 2 (value 0x04) sets on every write strobe that carries the opening-byte tag.
- R6: Status bit 3 (value 0x08) sets on a good-end, CRC-error or abort strobe, and on an overrun.
- R7: Status bit 4 (value 0x10) sets when a byte tagged as first becomes the read-head byte. This includes the case where a read exposes the next message's opening byte.
- R8: A write that finds the queue full sets bit 5 (value 0x20) and bit 3. Later writes without the opening tag are discarded, even after the queue has drained. The next opening byte is accepted, and the bytes stored before the overrun read out intact.
- R9: A host read returns {2'b00, status[5:0]} in the cycle `host_rd` is high. After that cycle, the bits read as 0.
- R10: An event in the same cycle as a host read leaves its bit set, so the next read returns it.
- R11: `irq` is high exactly when some status bit is set and its bit in `irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe from the deframer |
| wr_data | input | 8 | Byte to queue |
| wr_som | input | 1 | Byte is the first of a message |
| wr_eom | input | 1 | Byte is the last of a message |
| end_ok | input | 1 | Message finished with a good CRC |
| end_crc | input | 1 | Message finished with a CRC error |
| end_abort | input | 1 | Message aborted |
| rd_en | input | 1 | Pop the head byte |
| rd_valid | output | 1 | Queue holds at least one byte |
| rd_data | output | 8 | Head byte |
| rd_first | output | 1 | Head byte is the first of a message |
| rd_last | output | 1 | Head byte is the last of a message |
| hwm_level | input | 7 | High-water level, compared as count > level |
| irq_mask | input | 6 | Per-bit interrupt enables |
| host_rd | input | 1 | Host read-and-clear strobe for the status register |
| host_rdata | output | 8 | Status register value |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the high-water level over several values and fills the queue one byte at a time. It checks that bit 1 fires only at the single count that crosses the level. A design that compared with >= or re-fired while above the level would flag the wrong count. The bench drives the queue to exactly 64 entries and writes past it, then drains it and sends more bytes of the same packet. A design that dropped single bytes, or left discard mode early, would show a queue that never reaches full, corrupted data, or a stray byte. The bench also makes a strobe coincide with a host read, and pops back-to-back one-byte messages. A clear that wins over a set loses the event, and a plain edge detector on the head flag misses the second opening byte.

// File: rtl/hdlc_rxq_pkg.sv
`timescale 1ns/1ps
package hdlc_rxq_pkg;
   localparam int BYTE_W = 8;
   localparam int STAT_W = 6;

   // status bit positions (host-visible order)
   localparam int ST_NEMPTY = 0;
   localparam int ST_HIGH   = 1;
   localparam int ST_START  = 2;
   localparam int ST_END    = 3;
   localparam int ST_HEAD   = 4;
   localparam int ST_OVR    = 5;

   // bits whose event is the rising edge of a live level
   localparam logic [STAT_W-1:0] RISE_BITS = 6'b000011;

   typedef struct packed {
      logic              som;
      logic              eom;
      logic [BYTE_W-1:0] data;
   } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store
   import hdlc_rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  rxq_entry_t       push_ent,
   input  logic             pop,
   output rxq_entry_t       head_ent,
   output logic [CW-1:0]    count,
   output logic             empty,
   output logic             full
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxq_store: DEPTH must be a power of two, at least 4");
      end
   endgenerate

   rxq_entry_t       mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign empty    = (cnt_q == '0);
   assign full     = (cnt_q == CW'(DEPTH));
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign head_ent = mem[rptr];
   assign count    = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_ent;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop) |=> full);
endmodule

// File: rtl/rxq_admit.sv
`timescale 1ns/1ps
module rxq_admit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_som,
   input  logic full,
   output logic push,
   output logic ovr_evt,
   output logic discarding
);
   logic drop_q;
   logic skip;

   // while dropping, only an opening byte is looked at
   assign skip       = drop_q && !wr_som;
   assign ovr_evt    = wr_en && !skip && full;
   assign push       = wr_en && !skip && !full;
   assign discarding = drop_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                drop_q <= 1'b0;
      else if (ovr_evt)          drop_q <= 1'b1;
      else if (wr_en && wr_som)  drop_q <= 1'b0;
   end

   a_r8_enter_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !drop_q) |=> discarding);
   a_r8_no_push_dropping: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_q && wr_en && !wr_som) |-> !push);
endmodule

// File: rtl/rxq_evt_latch.sv
`timescale 1ns/1ps
module rxq_evt_latch
   import hdlc_rxq_pkg::*;
#(
   parameter int N = STAT_W,
   parameter logic [N-1:0] RISE_SEL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] pulse,
   input  logic         clr,
   output logic [N-1:0] stat
);
   logic [N-1:0] evt;
   logic [N-1:0] stat_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         if (RISE_SEL[i]) begin : g_rise
            logic prev_q;
            always_ff @(posedge clk) begin
               if (!rst_n) prev_q <= 1'b0;
               else        prev_q <= lvl[i];
            end
            assign evt[i] = pulse[i] | (lvl[i] & ~prev_q);
         end else begin : g_direct
            assign evt[i] = pulse[i] | lvl[i];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= evt[i] | (stat_q[i] & ~clr);
         end

         a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> stat[i]);
         a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[i]) |=> !stat[i]);
         a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr) |=> stat[i]);
      end
   endgenerate

   assign stat = stat_q;
endmodule

// File: rtl/hdlc_rxq_status.sv
`timescale 1ns/1ps
module hdlc_rxq_status
   import hdlc_rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_som,
   input  logic              wr_eom,
   input  logic              end_ok,
   input  logic              end_crc,
   input  logic              end_abort,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_first,
   output logic              rd_last,
   input  logic [CW-1:0]     hwm_level,
   input  logic [STAT_W-1:0] irq_mask,
   input  logic              host_rd,
   output logic [7:0]        host_rdata,
   output logic              irq
);
   generate
      if (STAT_W > 8) begin : g_bad_width
         $error("hdlc_rxq_status: status does not fit the 8-bit register");
      end
   endgenerate

   rxq_entry_t        in_ent, head_ent;
   logic [CW-1:0]     count;
   logic              empty, full, push, pop, ovr_evt, discarding;
   logic              head_first, hf_q, hf_evt;
   logic [STAT_W-1:0] lvl, pulse, stat;

   assign in_ent = '{som: wr_som, eom: wr_eom, data: wr_data};
   assign pop    = rd_en && !empty;

   rxq_admit u_admit (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_som     (wr_som),
      .full       (full),
      .push       (push),
      .ovr_evt    (ovr_evt),
      .discarding (discarding)
   );

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .push_ent (in_ent),
      .pop      (pop),
      .head_ent (head_ent),
      .count    (count),
      .empty    (empty),
      .full     (full)
   );

   // opening byte at the head: fires once per distinct head byte
   assign head_first = !empty && head_ent.som;
   always_ff @(posedge clk) begin
      if (!rst_n) hf_q <= 1'b0;
      else        hf_q <= head_first && !pop;
   end
   assign hf_evt = head_first && !hf_q;

   always_comb begin
      lvl   = '0;
      pulse = '0;
      lvl[ST_NEMPTY] = !empty;
      lvl[ST_HIGH]   = (count > hwm_level);
      pulse[ST_START] = wr_en && wr_som;
      pulse[ST_END]   = end_ok || end_crc || end_abort || ovr_evt;
      pulse[ST_HEAD]  = hf_evt;
      pulse[ST_OVR]   = ovr_evt;
   end

   rxq_evt_latch #(.N(STAT_W), .RISE_SEL(RISE_BITS)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .pulse (pulse),
      .clr   (host_rd),
      .stat  (stat)
   );

   assign rd_valid   = !empty;
   assign rd_data    = head_ent.data;
   assign rd_first   = head_ent.som;
   assign rd_last    = head_ent.eom;
   assign host_rdata = 8'(stat);
   assign irq        = |(stat & irq_mask);

   a_r8_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !(discarding && !wr_som)) |=> (stat[ST_OVR] && stat[ST_END]));
   a_r8_drop_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (discarding && wr_en && !wr_som) |=> (count <= $past(count)));
   a_r3_nonempty_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |=> stat[ST_NEMPTY]);
   a_r5_start_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_som) |=> stat[ST_START]);
endmodule

// File: tb/hdlc_rxq_status_bench.sv
`timescale 1ns/1ps
module hdlc_rxq_status_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 0, wr_som = 0, wr_eom = 0;
   logic [7:0] wr_data = '0;
   logic       end_ok = 0, end_crc = 0, end_abort = 0;
   logic       rd_en = 0, host_rd = 0;
   logic [6:0] hwm_level = '0;
   logic [5:0] irq_mask = '0;
   logic       rd_valid, rd_first, rd_last, irq;
   logic [7:0] rd_data, host_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   hdlc_rxq_status u_hdlc_rxq_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_som(wr_som), .wr_eom(wr_eom), .end_ok(end_ok), .end_crc(end_crc),
      .end_abort(end_abort), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_first(rd_first), .rd_last(rd_last),
      .hwm_level(hwm_level), .irq_mask(irq_mask), .host_rd(host_rd),
      .host_rdata(host_rdata), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic som, input logic eom);
      @(negedge clk);
      wr_en = 1; wr_data = d; wr_som = som; wr_eom = eom;
      @(negedge clk);
      wr_en = 0; wr_som = 0; wr_eom = 0;
   endtask

   task automatic pop_chk(input logic [7:0] d, input logic f, input logic l, input string tag);
      @(negedge clk);
      chk(rd_valid && rd_data == d && rd_first == f && rd_last == l, tag,
          {rd_valid, rd_first, rd_last, rd_data}, {1'b1, f, l, d});
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic pop_nc();
      @(negedge clk);
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
   endtask

   // one idle cycle, then a read-and-clear
   task automatic rdstat(output logic [7:0] v);
      @(negedge clk);
      host_rd = 1;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 0;
   endtask

   task automatic strobe(input int which);
      @(negedge clk);
      end_ok = (which == 0); end_crc = (which == 1); end_abort = (which == 2);
      @(negedge clk);
      end_ok = 0; end_crc = 0; end_abort = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!rd_valid && !irq, "R1 idle outputs", {rd_valid, irq}, 0);
      rdstat(v);
      chk(v == 8'h00, "R1 status after reset", v, 0);

      // R3 R5 R7 first byte
      hwm_level = 7'd3;
      wr(8'h11, 1, 0);
      rdstat(v);
      chk(v == 8'h15, "R3 R5 R7 first byte events", v, 8'h15);

      // R4 crossing, R3 no re-fire
      wr(8'h22, 0, 0); wr(8'h33, 0, 0); wr(8'h44, 0, 0); wr(8'h55, 0, 1);
      rdstat(v);
      chk(v == 8'h02, "R4 high-water crossing, R3 quiet", v, 8'h02);

      // R6 each end strobe
      for (int s = 0; s < 3; s++) begin
         strobe(s);
         rdstat(v);
         chk(v == 8'h08, "R6 end strobe", v, 8'h08);
      end

      // R2 order and flags
      pop_chk(8'h11, 1, 0, "R2 byte0");
      pop_chk(8'h22, 0, 0, "R2 byte1");
      pop_chk(8'h33, 0, 0, "R2 byte2");
      pop_chk(8'h44, 0, 0, "R2 byte3");
      pop_chk(8'h55, 0, 1, "R2 byte4");
      rdstat(v);
      chk(v == 8'h00 && !rd_valid, "R9 drained, nothing new", v, 0);

      // R10 event coincides with read
      @(negedge clk);
      end_ok = 1; host_rd = 1;
      #1 v = host_rdata;
      @(negedge clk);
      end_ok = 0; host_rd = 0;
      chk(v == 8'h00, "R10 read value before event", v, 0);
      rdstat(v);
      chk(v == 8'h08, "R10 event kept across clear", v, 8'h08);

      // R11 interrupt masking
      irq_mask = 6'h08;
      strobe(1);
      chk(irq == 1'b1, "R11 enabled bit raises irq", irq, 1);
      irq_mask = 6'h01;
      #1 chk(irq == 1'b0, "R11 masked bit quiet", irq, 0);
      irq_mask = 6'h3F;
      #1 chk(irq == 1'b1, "R11 all enabled", irq, 1);
      rdstat(v);
      @(negedge clk);
      chk(irq == 1'b0 && v == 8'h08, "R11 R9 irq drops after clear", {irq, v}, 8'h08);
      irq_mask = 6'h00;

      // R8 overrun
      for (int i = 0; i < 64; i++) wr(8'(i * 3 + 1), i == 0, 0);
      rdstat(v);
      wr(8'hEE, 0, 0); wr(8'hEE, 0, 0); wr(8'hEE, 0, 0);
      rdstat(v);
      chk(v == 8'h28, "R8 overrun flags", v, 8'h28);
      for (int i = 0; i < 64; i++) pop_chk(8'(i * 3 + 1), i == 0, 0, "R2 R8 stored bytes intact");
      @(negedge clk);
      chk(!rd_valid, "R2 exactly 64 held", rd_valid, 0);
      wr(8'h77, 0, 0);
      rdstat(v);
      chk(!rd_valid && v == 8'h00, "R8 discard continues after drain", {rd_valid, v}, 0);
      wr(8'hAB, 1, 1);
      @(negedge clk);
      chk(rd_valid && rd_data == 8'hAB && rd_first, "R8 opening byte resumes",
          {rd_valid, rd_first, rd_data}, {2'b11, 8'hAB});
      rdstat(v);
      chk(v == 8'h15, "R8 resumed packet events", v, 8'h15);
      pop_nc();

      // R7 back-to-back one-byte messages
      wr(8'h01, 1, 1); wr(8'h02, 1, 1);
      rdstat(v);
      pop_chk(8'h01, 1, 1, "R7 first message");
      rdstat(v);
      chk(v == 8'h10, "R7 next opening byte at head", v, 8'h10);
      pop_chk(8'h02, 1, 1, "R7 second message");
      rdstat(v);
      chk(v == 8'h00, "R7 nothing after drain", v, 0);

      // R4 sweep of the level
      for (int lv = 0; lv < 7; lv++) begin
         hwm_level = 7'(lv);
         for (int k = 1; k <= 8; k++) begin
            wr(8'(k), k == 1, 0);
            rdstat(v);
            chk(v[1] == (k == lv + 1), "R4 sweep crossing", {lv, k, v[1]}, {lv, k, 1'(k == lv + 1)});
         end
         for (int k = 0; k < 8; k++) pop_nc();
         rdstat(v);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule